// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This block sits between the register port of an SPI master and its serial shift engine. It holds one byte FIFO for transmit and one for receive. Software writes 32-bit words into the transmit side and reads 32-bit words, or single bytes, from the receive side. The shift engine on the other side drains transmit bytes and deposits received bytes one at a time, using pop and push strobes.

One event register reports both FIFO fill counts as live values. It also holds four latched flags. A receive-ready flag rises once the receive count passes a programmable threshold, or once the transfer has ended with bytes still waiting. A transmit-room flag rises while the free space meets a programmable threshold. Two sticky error flags record dropped pushes and pops from an empty FIFO. The flags are cleared by writing ones to them. A mask register selects which flags drive the single interrupt output. A global enable bit in the mode register flushes both FIFOs while it is low.

Register addresses on `reg_addr` are: 0 mode, 1 event, 2 mask, 3 transmit data, 4 receive data. Each FIFO holds `DEPTH` bytes, 32 by default, and `DEPTH` must be a power of two no larger than 32.

Top module: `spi_fifo_evt`

## Requirements
- R1: After reset the mode register reads 0x00000403 (enable bit 31 low, transmit threshold 4 in bits 15:8, receive threshold 3 in bits 7:0). The mask and event registers read 0, and `irq` is low.
- R2: While enabled, a write to address 3 with at least 4 free bytes appends the word's four bytes, bits 31:24 first. The transmit count in event bits 21:16 rises by 4. `tx_byte` shows the oldest byte, and `tx_pop` removes it.
- R3: Each `rx_push` appends `rx_byte` and raises the receive count in event bits 29:24. A word read (`reg_byte`=0) of address 4 pops up to four bytes, the oldest in bits 31:24. Positions with no byte read as zero.
- R4: A byte read (`reg_byte`=1) of address 4 pops exactly one byte into bits 7:0, with bits 31:8 zero.
- R5: Event bit 9 (receive ready) becomes set when the receive count exceeds the receive threshold, or when `xfer_end` is high and the receive count is nonzero. A count equal to the threshold does not set it.
- R6: Event bit 8 (transmit room) becomes set when DEPTH minus the transmit count is at least the transmit threshold.
- R7: Writing the event register clears each flag whose written bit is one. A flag whose condition still holds sets again on the following cycle. A sticky flag stays set until cleared.
- R8: `irq` is the OR of event bits 15:0 ANDed with mask bits 15:0. A zero mask keeps `irq` low.
- R9: A push to a full receive FIFO, or a transmit word write with fewer than 4 free bytes, is dropped whole and sets sticky event bit 12. A count never exceeds DEPTH.
- R10: A transmit pop or a receive read that finds fewer bytes than it takes sets sticky event bit 13. The missing bytes read as zero.
- R11: While mode bit 31 is low, both counts are held at zero and pushes are ignored. Re-enabling starts with both FIFOs empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 4) |
| reg_byte | input | 1 | Byte-wide access for a receive read |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as `reg_rd` |
| tx_pop | input | 1 | Shift engine takes one transmit byte |
| tx_byte | output | 8 | Oldest transmit byte, zero when empty |
| rx_push | input | 1 | Shift engine delivers one receive byte |
| rx_byte | input | 8 | Received byte |
| xfer_end | input | 1 | Transfer has ended (level) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a completely full FIFO that is then hit with one more push, because the drop must leave both the count and the stored data untouched. The stimulus fills the receive side with 33 pushes and the transmit side with 9 word writes. It then drains all 32 bytes through the scoreboard to show that nothing of the extra item entered. The threshold boundaries are reached by moving the thresholds rather than the data. This includes a count equal to the receive threshold and a free space one short of the transmit threshold. Each flag is cleared first, so that a flag cannot pass the check just by staying set.

// File: rtl/spi_fifo_evt.sv
module spi_fifo_evt #(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic        reg_byte,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tx_pop,
  output logic [7:0]  tx_byte,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        xfer_end,
  output logic        irq
);
  localparam int PW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [2:0] A_MODE = 3'd0, A_EVT = 3'd1, A_MASK = 3'd2, A_TXD = 3'd3, A_RXD = 3'd4;

  logic [7:0] txm [DEPTH];
  logic [7:0] rxm [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic [31:0] mode, mask;
  logic ev_ne, ev_nf, ev_ovf, ev_unf;

  wire en = mode[31];
  wire [CNT_W-1:0] tx_free = FULL - tx_cnt;
  wire tx_wr      = en && reg_wr && reg_addr == A_TXD;
  wire tx_wr_ok   = tx_wr && tx_free >= CNT_W'(4);
  wire tx_pop_ok  = en && tx_pop && tx_cnt != '0;
  wire rx_push_ok = en && rx_push && rx_cnt != FULL;
  wire rx_rd      = en && reg_rd && reg_addr == A_RXD;
  wire [CNT_W-1:0] rx_want = reg_byte ? CNT_W'(1) : CNT_W'(4);
  wire [CNT_W-1:0] rx_npop = !rx_rd ? '0 : (rx_cnt < rx_want ? rx_cnt : rx_want);

  wire ovf_set = (tx_wr && !tx_wr_ok) || (en && rx_push && !rx_push_ok);
  wire unf_set = (en && tx_pop && tx_cnt == '0) || (rx_rd && rx_cnt < rx_want);
  wire ne_cond = en && (8'(rx_cnt) > mode[7:0] || (xfer_end && rx_cnt != '0));
  wire nf_cond = en && 8'(tx_free) >= mode[15:8];
  wire [31:0] clr = (reg_wr && reg_addr == A_EVT) ? reg_wdata : '0;

  wire [31:0] evt = {2'b0, 6'(rx_cnt), 2'b0, 6'(tx_cnt), 2'b0, ev_unf, ev_ovf,
                     2'b0, ev_ne, ev_nf, 8'b0};

  logic [31:0] rx_word;
  always_comb begin
    for (int i = 0; i < 4; i++)
      rx_word[31-8*i -: 8] = (CNT_W'(i) < rx_cnt) ? rxm[rx_rp + PW'(i)] : 8'h00;
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = mode;
      A_EVT:   reg_rdata = evt;
      A_MASK:  reg_rdata = mask;
      A_RXD:   reg_rdata = reg_byte ? {24'b0, rx_word[31:24]} : rx_word;
      default: reg_rdata = '0;
    endcase
  end

  assign tx_byte = (tx_cnt != '0) ? txm[tx_rp] : 8'h00;
  assign irq     = |(evt[15:0] & mask[15:0]);

  always_ff @(posedge clk) begin
    if (tx_wr_ok)
      for (int i = 0; i < 4; i++) txm[tx_wp + PW'(i)] <= reg_wdata[31-8*i -: 8];
    if (rx_push_ok) rxm[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (!en) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_wr_ok) tx_wp <= tx_wp + PW'(4);
      if (tx_pop_ok) tx_rp <= tx_rp + PW'(1);
      tx_cnt <= tx_cnt + (tx_wr_ok ? CNT_W'(4) : '0) - CNT_W'(tx_pop_ok);
      if (rx_push_ok) rx_wp <= rx_wp + PW'(1);
      rx_rp  <= rx_rp + PW'(rx_npop);
      rx_cnt <= rx_cnt + CNT_W'(rx_push_ok) - rx_npop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= 32'h0000_0403;
      mask <= '0;
      ev_ne <= 1'b0; ev_nf <= 1'b0; ev_ovf <= 1'b0; ev_unf <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_MODE) mode <= reg_wdata;
      if (reg_wr && reg_addr == A_MASK) mask <= reg_wdata;
      ev_nf  <= nf_cond | (ev_nf  & ~clr[8]);
      ev_ne  <= ne_cond | (ev_ne  & ~clr[9]);
      ev_ovf <= ovf_set | (ev_ovf & ~clr[12]);
      ev_unf <= unf_set | (ev_unf & ~clr[13]);
    end
  end
endmodule

// File: rtl/spi_fifo_evt_chk.sv
module spi_fifo_evt_chk #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      mode,
  input logic [31:0]      mask,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt,
  input logic             rx_push,
  input logic             reg_rd,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [7:0]       tx_byte,
  input logic             irq,
  input logic             ev_ovf
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= FULL && tx_cnt <= FULL);  // R9
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    mode[31] && rx_push && rx_cnt == FULL && !reg_rd && !(reg_wr && reg_addr == 3'd0)
    |=> rx_cnt == FULL && ev_ovf);  // R9
  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[31] |=> rx_cnt == '0 && tx_cnt == '0);  // R11
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt == '0 |-> tx_byte == 8'h00);  // R10
  AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    mask[15:0] == '0 |-> !irq);  // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf && !(reg_wr && reg_addr == 3'd1 && reg_wdata[12]) |=> ev_ovf);  // R7
endmodule

bind spi_fifo_evt spi_fifo_evt_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/spi_fifo_evt_tb_top.sv
module spi_fifo_evt_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, reg_byte = 0, tx_pop = 0, rx_push = 0, xfer_end = 0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0] tx_byte, rx_byte = '0;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  logic [31:0] v;

  always #5 clk = ~clk;

  spi_fifo_evt dut_i (.*);

  task automatic chk(string r, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, logic byt, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; reg_byte = byt;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0; reg_byte = 0;
  endtask

  task automatic push_rx(logic [7:0] b, bit keep);
    @(negedge clk); rx_push = 1; rx_byte = b;
    if (keep) rx_q.push_back(b);
    @(negedge clk); rx_push = 0;
  endtask

  task automatic write_tx(logic [31:0] w, bit keep);
    if (keep) for (int i = 0; i < 4; i++) tx_q.push_back(w[31-8*i -: 8]);
    wr(3'd3, w);
  endtask

  task automatic pop_tx(string r);
    logic [7:0] e;
    e = (tx_q.size() > 0) ? tx_q.pop_front() : 8'h00;
    @(negedge clk); tx_pop = 1;
    #1 chk(r, {24'b0, tx_byte}, {24'b0, e});
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic read_rx_word(string r);
    logic [31:0] e, got;
    e = '0;
    for (int i = 0; i < 4; i++) if (rx_q.size() > 0) e[31-8*i -: 8] = rx_q.pop_front();
    rd(3'd4, 1'b0, got);
    chk(r, got, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(3'd0, 0, v); chk("R1 mode", v, 32'h0000_0403);
    rd(3'd2, 0, v); chk("R1 mask", v, 32'h0);
    rd(3'd1, 0, v); chk("R1 event", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    wr(3'd0, 32'h8000_0403);
    rd(3'd1, 0, v); chk("R6 room set", {31'b0, v[8]}, 1);
    wr(3'd0, 32'h8000_2103);
    wr(3'd1, 32'h0000_0100);
    rd(3'd1, 0, v); chk("R7 cleared", {31'b0, v[8]}, 0);
    wr(3'd0, 32'h8000_0403);
    rd(3'd1, 0, v); chk("R7 sets again", {31'b0, v[8]}, 1);

    write_tx(32'h1122_3344, 1);
    write_tx(32'hA5B6_C7D8, 1);
    rd(3'd1, 0, v); chk("R2 tx count", {26'b0, v[21:16]}, 8);
    wr(3'd0, 32'h8000_1903);
    wr(3'd1, 32'h0000_0100);
    rd(3'd1, 0, v); chk("R6 free 24 below 25", {31'b0, v[8]}, 0);
    for (int i = 0; i < 8; i++) pop_tx("R2 tx byte order");
    rd(3'd1, 0, v); chk("R6 free 32 meets 25", {31'b0, v[8]}, 1);
    wr(3'd0, 32'h8000_0403);
    pop_tx("R10 empty tx byte");
    rd(3'd1, 0, v); chk("R10 underflow flag", {31'b0, v[13]}, 1);

    push_rx(8'h10, 1); push_rx(8'h20, 1); push_rx(8'h30, 1);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, 0, v);
    chk("R5 count equals thr", {31'b0, v[9]}, 0);
    chk("R3 rx count", {26'b0, v[29:24]}, 3);
    push_rx(8'h40, 1);
    rd(3'd1, 0, v); chk("R5 count above thr", {31'b0, v[9]}, 1);
    read_rx_word("R3 word read");
    rd(3'd1, 0, v); chk("R3 rx count drained", {26'b0, v[29:24]}, 0);

    push_rx(8'h5A, 1); push_rx(8'h6B, 1);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, 0, v); chk("R5 no end", {31'b0, v[9]}, 0);
    xfer_end = 1;
    rd(3'd1, 0, v); chk("R5 end with data", {31'b0, v[9]}, 1);
    rd(3'd4, 1, v); chk("R4 byte read 1", v, {24'b0, rx_q.pop_front()});
    rd(3'd4, 1, v); chk("R4 byte read 2", v, {24'b0, rx_q.pop_front()});
    xfer_end = 0;

    push_rx(8'h77, 1);
    wr(3'd1, 32'hFFFF_FFFF);
    read_rx_word("R10 partial word");
    rd(3'd1, 0, v); chk("R10 underflow on partial", {31'b0, v[13]}, 1);

    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'h0);
    rd(3'd1, 0, v); chk("R8 room pending", {31'b0, v[8]}, 1);
    chk("R8 zero mask", {31'b0, irq}, 0);
    wr(3'd2, 32'h0000_0100); chk("R8 room unmasked", {31'b0, irq}, 1);
    wr(3'd2, 32'h0000_0200); chk("R8 ready unmasked idle", {31'b0, irq}, 0);
    wr(3'd2, 32'h0);

    wr(3'd1, 32'hFFFF_FFFF);
    for (int i = 0; i < 33; i++) push_rx(8'(i * 3 + 1), i < 32);
    rd(3'd1, 0, v);
    chk("R9 rx count full", {26'b0, v[29:24]}, 32);
    chk("R9 overflow flag", {31'b0, v[12]}, 1);
    for (int i = 0; i < 8; i++) read_rx_word("R9 stored data intact");
    for (int i = 0; i < 9; i++) write_tx(32'h0101_0101 * (i + 1), i < 8);
    rd(3'd1, 0, v); chk("R9 tx count full", {26'b0, v[21:16]}, 32);
    pop_tx("R9 tx first byte");

    wr(3'd0, 32'h0000_0403);
    tx_q.delete(); rx_q.delete();
    rd(3'd1, 0, v); chk("R11 counts flushed", v & 32'h3F3F_0000, 32'h0);
    push_rx(8'hEE, 0);
    rd(3'd1, 0, v); chk("R11 push ignored", {26'b0, v[29:24]}, 0);
    pop_tx("R11 tx empty while off");
    wr(3'd0, 32'h8000_0403);
    rd(3'd1, 0, v); chk("R11 empty after enable", v & 32'h3F3F_0000, 32'h0);
    read_rx_word("R11 rx empty after enable");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule